// File: doc/BRIEF.md
# Clock Multiplier Change Sequencer

This block sits in a clock generator and decides when a newly written frequency-multiplier code reaches the PLL. Software writes a multiplier code, an apply-now bit and a settling-time select through a single register write port. With the apply-now bit clear, the code is only stored as pending. It is moved to the PLL when the chip enters a low-power state (software standby, watch or subactive), and the clock is stopped at that moment. With the apply-now bit set, the code drives the PLL on the next cycle.

On a wake event the block restarts the clock. It then keeps the core halted for a settling count chosen by the 3-bit select, and releases the core only when that count has run out. The core then runs at the new factor. The analog PLL and the oscillator are outside the block. The PLL is represented only by the code the block drives.

Top module: `clk_mult_seq`

## Requirements
- R1: After reset, mult_code is 00, core_run is 1 and clk_stop is 0. The stored pending code is 00, the apply-now bit is 0 and the settle select is 0.
- R2: The multiplier field encodes 00 = x1, 01 = x2 and 10 = x4. A write that carries 11 leaves the pending and active codes unchanged, while the other fields of that write are still stored. mult_code is never 11.
- R3: A write with wr_imm = 0 and a legal code changes only the pending code, so mult_code keeps its value. The pending code is copied to mult_code on the same cycle that clk_stop rises.
- R4: A write with wr_imm = 1 and a legal code appears on mult_code on the cycle after the write, in any state. If a standby entry falls on the same cycle, the written code wins.
- R5: A sby_req seen while running sets clk_stop to 1 and core_run to 0 on the next cycle.
- R6: A wake seen while stopped clears clk_stop on the next cycle. core_run rises exactly N cycles later, where N = max(1, 2^E >> SETTLE_SHIFT) and E is 13, 14, 15, 16, 17, 18, 10 or 11 for a stored select of 0 to 7. The select is the one held when the wake arrives.
- R7: A wake while running or during the settling count has no effect on clk_stop, core_run or the settling length. A sby_req while stopped has no effect.
- R8: A sby_req during the settling count is held. When the count ends, the block re-enters standby directly: clk_stop becomes 1, core_run stays 0, and the pending code is copied to mult_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_mult | input | 2 | Multiplier code to write |
| wr_imm | input | 1 | Apply-now bit to write |
| wr_wsel | input | 3 | Settling-time select to write |
| sby_req | input | 1 | Low-power state entry request |
| wake | input | 1 | Wake event from the low-power state |
| clk_stop | output | 1 | Clock stopped while high |
| mult_code | output | 2 | Active multiplier code to the PLL |
| core_run | output | 1 | Core operation enable |

## Verification
Deferred writes are checked against immediate ones. The deferred case shows whether mult_code moves at the write or only at the rise of clk_stop. Writes of the reserved code come after a legal pending code, so a design that keeps the old value can be told from one that stores 11 or clears to 00. Settling runs use several selects, including the two short selects that wrap in the table, and each run is measured to the exact cycle. A wake is injected in the middle of a settling run to show that it is ignored. A standby request in the same window must produce a direct return to the stopped state. The directed cases are followed by seeded random write, standby and wake rounds checked against a bench model.

// File: rtl/clk_mult_seq_pkg.sv
package clk_mult_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_t;

  localparam logic [1:0] MULT_RSVD = 2'b11;

  // log2 of the settling length in reference cycles for each select value
  function automatic int unsigned settle_log2(input logic [2:0] sel);
    case (sel)
      3'd0:    return 13;
      3'd1:    return 14;
      3'd2:    return 15;
      3'd3:    return 16;
      3'd4:    return 17;
      3'd5:    return 18;
      3'd6:    return 10;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned settle_cycles(input logic [2:0] sel, input int unsigned shift);
    int unsigned v;
    v = (32'd1 << settle_log2(sel)) >> shift;
    if (v == 0) v = 1;
    return v;
  endfunction

endpackage

// File: rtl/cms_regs.sv
module cms_regs #(
  parameter int MULT_W = 2,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MULT_W-1:0] wr_mult,
  input  logic              wr_imm,
  input  logic [WSEL_W-1:0] wr_wsel,
  input  logic              stop_entry,
  output logic [MULT_W-1:0] active_code,
  output logic [WSEL_W-1:0] wsel
);
  import clk_mult_seq_pkg::*;

  logic [MULT_W-1:0] pend_code;
  logic              imm_bit;
  logic              code_ok;
  logic              apply_now;

  assign code_ok   = (wr_mult != MULT_W'(MULT_RSVD));
  assign apply_now = wr_en && wr_imm && code_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code <= '0;
      imm_bit   <= 1'b0;
      wsel      <= '0;
    end else if (wr_en) begin
      imm_bit <= wr_imm;
      wsel    <= wr_wsel;
      if (code_ok) pend_code <= wr_mult;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_code <= '0;
    end else if (apply_now) begin
      active_code <= wr_mult;
    end else if (stop_entry) begin
      active_code <= pend_code;
    end
  end

  // R2: a reserved code leaves the pending value untouched
  a_r2_reserved_keeps_pending: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mult == MULT_W'(MULT_RSVD)) |=> $stable(pend_code));

  // R2: the PLL never sees the reserved code
  a_r2_active_code_legal: assert property (@(posedge clk) disable iff (rst)
    active_code != MULT_W'(MULT_RSVD));

  // R3: without an apply-now write or a standby entry the active code holds
  a_r3_active_holds: assert property (@(posedge clk) disable iff (rst)
    (!apply_now && !stop_entry) |=> $stable(active_code));

  // R4: an apply-now write lands on the next cycle
  a_r4_immediate_lands: assert property (@(posedge clk) disable iff (rst)
    apply_now |=> active_code == $past(wr_mult));

endmodule

// File: rtl/cms_settle_timer.sv
module cms_settle_timer #(
  parameter int WSEL_W       = 3,
  parameter int CNT_W        = 19,
  parameter int SETTLE_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WSEL_W-1:0] sel,
  output logic              done
);
  import clk_mult_seq_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(settle_cycles(3'(sel), SETTLE_SHIFT) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  // R6: the counter never wraps below zero
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && done) |=> done);

endmodule

// File: rtl/cms_seq_fsm.sv
module cms_seq_fsm (
  input  logic clk,
  input  logic rst,
  input  logic sby_req,
  input  logic wake,
  input  logic settle_done,
  output logic stop_entry,
  output logic settle_load,
  output logic clk_stop,
  output logic core_run
);
  import clk_mult_seq_pkg::*;

  seq_state_t state;
  logic       sby_held;

  always_comb begin
    stop_entry  = ((state == ST_RUN) && sby_req) ||
                  ((state == ST_SETTLE) && settle_done && (sby_held || sby_req));
    settle_load = (state == ST_STOP) && wake;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      clk_stop <= 1'b0;
      core_run <= 1'b1;
      sby_held <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (sby_req) begin
            state    <= ST_STOP;
            clk_stop <= 1'b1;
            core_run <= 1'b0;
          end
        end
        ST_STOP: begin
          if (wake) begin
            state    <= ST_SETTLE;
            clk_stop <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            sby_held <= 1'b0;
            if (sby_held || sby_req) begin
              state    <= ST_STOP;
              clk_stop <= 1'b1;
            end else begin
              state    <= ST_RUN;
              core_run <= 1'b1;
            end
          end else if (sby_req) begin
            sby_held <= 1'b1;
          end
        end
        default: begin
          state    <= ST_RUN;
          clk_stop <= 1'b0;
          core_run <= 1'b1;
        end
      endcase
    end
  end

  // R5: the clock stops only after a request
  a_r5_stop_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_stop) |-> $past(sby_req) || $past(sby_held));

  // R5: stopped clock and running core never coincide
  a_r5_stop_excludes_run: assert property (@(posedge clk) disable iff (rst)
    !(clk_stop && core_run));

  // R7: a wake while running changes nothing
  a_r7_wake_in_run_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && wake && !sby_req) |=> (core_run && !clk_stop));

  // R6: the core stays halted until the settling count ends
  a_r6_halted_while_settling: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && !settle_done) |=> !core_run);

endmodule

// File: rtl/clk_mult_seq.sv
module clk_mult_seq #(
  parameter int MULT_W       = 2,
  parameter int WSEL_W       = 3,
  parameter int MAX_LOG2     = 18,
  parameter int SETTLE_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MULT_W-1:0] wr_mult,
  input  logic              wr_imm,
  input  logic [WSEL_W-1:0] wr_wsel,
  input  logic              sby_req,
  input  logic              wake,
  output logic              clk_stop,
  output logic [MULT_W-1:0] mult_code,
  output logic              core_run
);
  localparam int CNT_W = MAX_LOG2 + 1;

  logic              stop_entry;
  logic              settle_load;
  logic              settle_done;
  logic [WSEL_W-1:0] wsel;

  cms_regs #(.MULT_W(MULT_W), .WSEL_W(WSEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mult(wr_mult), .wr_imm(wr_imm),
    .wr_wsel(wr_wsel), .stop_entry(stop_entry), .active_code(mult_code), .wsel(wsel)
  );

  cms_settle_timer #(.WSEL_W(WSEL_W), .CNT_W(CNT_W), .SETTLE_SHIFT(SETTLE_SHIFT)) u_timer (
    .clk(clk), .rst(rst), .load(settle_load), .sel(wsel), .done(settle_done)
  );

  cms_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .sby_req(sby_req), .wake(wake), .settle_done(settle_done),
    .stop_entry(stop_entry), .settle_load(settle_load), .clk_stop(clk_stop), .core_run(core_run)
  );

endmodule

// File: tb/test_clk_mult_seq.sv
module test_clk_mult_seq;
  localparam int SH = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_mult = '0;
  logic       wr_imm = 1'b0;
  logic [2:0] wr_wsel = '0;
  logic       sby_req = 1'b0;
  logic       wake = 1'b0;
  logic       clk_stop;
  logic [1:0] mult_code;
  logic       core_run;

  int checks = 0;
  int fails = 0;
  logic [1:0] m_pend = 2'b00;
  logic [1:0] m_act = 2'b00;
  logic [2:0] m_wsel = 3'd0;

  always #2.5 clk = ~clk;

  clk_mult_seq #(.SETTLE_SHIFT(SH)) i_clk_mult_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mult(wr_mult), .wr_imm(wr_imm),
    .wr_wsel(wr_wsel), .sby_req(sby_req), .wake(wake), .clk_stop(clk_stop),
    .mult_code(mult_code), .core_run(core_run)
  );

  function automatic int exp_len(input logic [2:0] sel);
    int e[8] = '{13, 14, 15, 16, 17, 18, 10, 11};
    int v;
    v = (1 << e[sel]) >> SH;
    if (v == 0) v = 1;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] c, input logic imm, input logic [2:0] ws);
    wr_en = 1'b1; wr_mult = c; wr_imm = imm; wr_wsel = ws;
    @(negedge clk);
    wr_en = 1'b0;
    m_wsel = ws;
    if (c != 2'b11) begin
      m_pend = c;
      if (imm) m_act = c;
    end
  endtask

  task automatic do_standby();
    sby_req = 1'b1;
    @(negedge clk);
    sby_req = 1'b0;
    m_act = m_pend;
    check("R5 clk_stop", clk_stop, 1);
    check("R5 core_run", core_run, 0);
    check("R3 code at stop", mult_code, m_act);
  endtask

  // inject: 0 none, 1 wake mid-settle, 2 standby mid-settle
  task automatic do_wake(input int inject);
    int n;
    int len;
    len = exp_len(m_wsel);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check("R6 clock restarts", clk_stop, 0);
    n = 0;
    do begin
      if (n == 1 && len > 3 && inject == 1) wake = 1'b1;
      if (n == 1 && len > 3 && inject == 2) sby_req = 1'b1;
      @(negedge clk);
      wake = 1'b0; sby_req = 1'b0;
      n++;
    end while (!core_run && !clk_stop && n < 5000);
    if (inject == 2) begin
      m_act = m_pend;
      check("R8 restop length", n, len);
      check("R8 clk_stop", clk_stop, 1);
      check("R8 core held", core_run, 0);
      check("R8 code applied", mult_code, m_act);
    end else begin
      check(inject == 1 ? "R7 wake ignored, length" : "R6 settle length", n, len);
      check("R6 core_run", core_run, 1);
      check("R6 clk_stop", clk_stop, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mult_code", mult_code, 0);
    check("R1 core_run", core_run, 1);
    check("R1 clk_stop", clk_stop, 0);

    // R7: wake while running is ignored
    wake = 1'b1; @(negedge clk); wake = 1'b0; @(negedge clk);
    check("R7 run wake core", core_run, 1);
    check("R7 run wake stop", clk_stop, 0);

    // R3: deferred write holds off
    do_write(2'b01, 1'b0, 3'd6);
    check("R3 deferred", mult_code, 0);
    repeat (2) @(negedge clk);
    check("R3 still deferred", mult_code, 0);
    do_standby();
    check("R3 x2 active", mult_code, 1);
    // R7: standby while stopped has no effect
    sby_req = 1'b1; @(negedge clk); sby_req = 1'b0;
    check("R7 stop sby", clk_stop, 1);
    do_wake(0);

    // R2: reserved code keeps pending x4
    do_write(2'b10, 1'b0, 3'd7);
    do_write(2'b11, 1'b0, 3'd7);
    check("R2 reserved no change", mult_code, 1);
    do_standby();
    check("R2 pending kept", mult_code, 2);
    do_wake(1);

    // R4: immediate apply, then reserved with imm
    do_write(2'b00, 1'b1, 3'd0);
    check("R4 immediate", mult_code, 0);
    do_write(2'b11, 1'b1, 3'd6);
    check("R2 reserved imm", mult_code, 0);

    // R4: coincident standby and immediate write
    wr_en = 1'b1; wr_mult = 2'b01; wr_imm = 1'b1; wr_wsel = 3'd6; sby_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sby_req = 1'b0;
    m_pend = 2'b01; m_act = 2'b01; m_wsel = 3'd6;
    check("R4 write wins", mult_code, 1);
    check("R5 coincident stop", clk_stop, 1);

    // R8: deferred write and standby during settling
    do_write(2'b10, 1'b0, 3'd6);
    check("R4 imm write in stop none", mult_code, 1);
    do_wake(2);
    do_wake(0);

    // R6: select 0
    do_write(2'b00, 1'b0, 3'd0);
    do_standby();
    do_wake(0);

    // Random rounds
    for (int i = 0; i < 25; i++) begin
      logic [1:0] c;
      logic imm;
      logic [2:0] ws;
      c = 2'($urandom);
      imm = 1'($urandom);
      ws = 3'($urandom % 8);
      if (ws > 3 && ws < 6) ws = 3'(ws + 2);
      do_write(c, imm, ws);
      check("R3/R4 random code", mult_code, m_act);
      do_standby();
      do_wake(($urandom % 4 == 0) ? 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule